// File: doc/BRIEF.md
# Dual-Mode Serial Channel

One full-duplex serial channel for a host that reaches it through register-style strobes. Bytes the host writes go into a two-entry transmit queue. Received bytes collect in a four-entry receive queue, and the host reads them from the head of that queue. A static mode input picks between two line disciplines. The first is an asynchronous character format with 7- or 8-bit data and optional even or odd parity. The second is an 8-bit clocked-synchronous exchange that uses an active-low serial clock and an active-low ready line. In master role the block drives the clock and senses ready. In slave role it senses the clock and drives ready.

Bit timing comes from an external clock-enable pulse, `baud_tick`. In asynchronous mode one bit lasts sixteen ticks. In synchronous master mode each half of the serial clock lasts one tick. Three level outputs feed an interrupt controller: transmit queue empty, received data present, and a sticky receive-error flag. The error flag collects framing, parity and overrun faults.

Top module: `sio_channel`

## Requirements
- R1: After reset the outputs hold these values: `tx_empty`=1, `rx_avail`=0, `rx_err`=0, `txd`=1, `sck_n_o`=1, `sck_n_oe`=0, `rdy_n_oe`=0.
- R2: In asynchronous mode a frame is sent in this order. First a low start bit, then the data bits least significant first (7 bits when `char7`=1, otherwise 8). Then, if `par_en`=1, a parity bit equal to the XOR of the data bits XOR `par_odd`. Last comes one high stop bit. Each bit lasts 16 ticks of `baud_tick`, and the line idles high.
- R3: The asynchronous receiver finds a start bit and samples every bit at its middle. It stores the received character with bit 7 forced to 0 in 7-bit mode. Any byte sent in looped-back asynchronous mode comes back unchanged, for every mix of character size and parity setting.
- R4: The transmit queue holds 2 bytes. A write when it is full is dropped. When 4 bytes are written on back-to-back cycles while the transmitter is idle, exactly the first 3 are sent. `tx_empty` returns to 1 once the queue has drained.
- R5: The receive queue holds 4 bytes, and `rd_data` always shows the oldest byte. A read strobe on an empty queue has no effect.
- R6: If a character completes while the receive queue is full, that character is discarded, `rx_err` rises, and the 4 stored bytes stay intact.
- R7: A low stop bit is a framing error and sets `rx_err`. The character is still stored.
- R8: When parity is enabled, a parity bit that does not match sets `rx_err`. A matching parity bit leaves `rx_err` at 0.
- R9: `rx_err` stays at 1 until a one-cycle `err_clr` strobe clears it.
- R10: In synchronous master mode (`mode_sync`=1, `sync_master`=1) the block drives `sck_n_oe`=1 and sends 8 bits least significant first. `txd` changes when `sck_n_o` falls. `rxd` is sampled when `sck_n_o` rises, so the byte shifted in at the same time is stored.
- R11: A synchronous master starts a byte only while `rdy_n_i` is low. While `rdy_n_i` is high, a queued byte stays queued and `sck_n_o` stays high.
- R12: In synchronous slave mode (`sync_master`=0) `sck_n_i` clocks the transfer, and `rdy_n_oe`=1. The block sends the head of the transmit queue, or 0xFF when the queue is empty, and receives one byte every 8 clocks. `rdy_n_o` is low only while the receive queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 1 = clocked-synchronous, 0 = asynchronous |
| sync_master | input | 1 | Synchronous role: 1 = drive clock, 0 = follow clock |
| char7 | input | 1 | Asynchronous 7-bit characters when 1 |
| par_en | input | 1 | Asynchronous parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| baud_tick | input | 1 | Bit-timing clock enable |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Pop the receive queue head |
| rd_data | output | 8 | Oldest received byte |
| err_clr | input | 1 | Clear strobe for `rx_err` |
| tx_empty | output | 1 | Transmit queue empty |
| rx_avail | output | 1 | Receive queue not empty |
| rx_err | output | 1 | Sticky framing/parity/overrun flag |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sck_n_o | output | 1 | Serial clock driven in master role |
| sck_n_oe | output | 1 | Output enable for the serial clock |
| sck_n_i | input | 1 | Serial clock sensed in slave role |
| rdy_n_o | output | 1 | Ready driven in slave role (low = room) |
| rdy_n_oe | output | 1 | Output enable for ready |
| rdy_n_i | input | 1 | Ready sensed in master role |

## Verification
A host write is pushed on the next edge, and an idle transmitter pops it one edge later. The asynchronous start bit therefore appears within two cycles, and the bench samples each bit 16 cycles into its 32-cycle span (one tick every other cycle). A received byte is visible at `rd_data` one edge after the receiver's stop-bit or eighth-rising-edge sample, and `rx_err` is set on that same edge. The bench waits a full bit time, or polls with a bound, before it compares. Inputs sensed in slave role pass two synchronizer stages and one edge detector, so the bench holds each serial clock phase for 8 cycles and samples `txd` at the end of the low phase.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
  typedef enum logic [2:0] {AT_IDLE, AT_START, AT_DATA, AT_PAR, AT_STOP} async_st_e;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = ptr_inc(wp_q);
    if (do_pop)  rp_d = ptr_inc(rp_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_data;
  end

  // R4 (transmit) and R5 (receive): writes into a full queue are dropped
  a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (cnt_q == CW'(DEPTH)));
  // R5: popping an empty queue leaves it empty
  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (cnt_q == '0));
endmodule

// File: rtl/sio_async_tx.sv
module sio_async_tx
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  char7,
  input  logic  par_en,
  input  logic  par_odd,
  input  logic  q_empty,
  input  char_t q_head,
  output logic  q_pop,
  output logic  txd_o
);
  localparam int TKW = $clog2(OVERSAMPLE);

  async_st_e      st_q, st_d;
  logic [TKW-1:0] tk_q, tk_d;
  logic [2:0]     bit_q, bit_d;
  char_t          sh_q, sh_d;
  logic           par_q, par_d;
  logic           last_tk, last_bit;
  char_t          mask;

  assign mask     = char7 ? char_t'(8'h7F) : char_t'(8'hFF);
  assign last_tk  = (tk_q == TKW'(OVERSAMPLE - 1));
  assign last_bit = (bit_q == (char7 ? 3'd6 : 3'd7));

  always_comb begin
    st_d  = st_q;
    tk_d  = tk_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    par_d = par_q;
    q_pop = 1'b0;
    if (st_q == AT_IDLE) begin
      if (en && !q_empty) begin
        q_pop = 1'b1;
        sh_d  = q_head;
        par_d = (^(q_head & mask)) ^ par_odd;
        st_d  = AT_START;
        tk_d  = '0;
        bit_d = '0;
      end
    end else if (tick) begin
      tk_d = tk_q + 1'b1;
      if (last_tk) begin
        tk_d = '0;
        case (st_q)
          AT_START: st_d = AT_DATA;
          AT_DATA: begin
            sh_d  = sh_q >> 1;
            bit_d = bit_q + 1'b1;
            if (last_bit) st_d = par_en ? AT_PAR : AT_STOP;
          end
          AT_PAR:  st_d = AT_STOP;
          default: st_d = AT_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AT_IDLE;
      tk_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tk_q  <= tk_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    case (st_q)
      AT_START: txd_o = 1'b0;
      AT_DATA:  txd_o = sh_q[0];
      AT_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  // R2: inside a frame the line only moves on a timing tick
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != AT_IDLE && !tick) |=> $stable(txd_o));
endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  char7,
  input  logic  par_en,
  input  logic  par_odd,
  input  logic  rxd_s,
  output logic  done,
  output char_t data,
  output logic  ferr,
  output logic  perr
);
  localparam int TKW = $clog2(OVERSAMPLE);
  localparam logic [TKW-1:0] MID = TKW'(OVERSAMPLE / 2 - 1);

  async_st_e      st_q, st_d;
  logic [TKW-1:0] tk_q, tk_d;
  logic [2:0]     bit_q, bit_d;
  char_t          sh_q, sh_d;
  logic           pe_q, pe_d;
  logic           last_tk, last_bit;

  assign last_tk  = (tk_q == TKW'(OVERSAMPLE - 1));
  assign last_bit = (bit_q == (char7 ? 3'd6 : 3'd7));
  assign data     = char7 ? {1'b0, sh_q[7:1]} : sh_q;

  always_comb begin
    st_d  = st_q;
    tk_d  = tk_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    pe_d  = pe_q;
    done  = 1'b0;
    ferr  = 1'b0;
    perr  = 1'b0;
    if (tick) begin
      tk_d = tk_q + 1'b1;
      case (st_q)
        AT_IDLE: begin
          tk_d = '0;
          if (en && !rxd_s) st_d = AT_START;
        end
        AT_START: begin
          if (tk_q == MID) begin
            tk_d  = '0;
            bit_d = '0;
            pe_d  = 1'b0;
            st_d  = rxd_s ? AT_IDLE : AT_DATA;
          end
        end
        AT_DATA: begin
          if (last_tk) begin
            tk_d  = '0;
            sh_d  = {rxd_s, sh_q[7:1]};
            bit_d = bit_q + 1'b1;
            if (last_bit) st_d = par_en ? AT_PAR : AT_STOP;
          end
        end
        AT_PAR: begin
          if (last_tk) begin
            tk_d = '0;
            pe_d = rxd_s ^ (^data) ^ par_odd;
            st_d = AT_STOP;
          end
        end
        default: begin
          if (last_tk) begin
            tk_d = '0;
            done = 1'b1;
            ferr = ~rxd_s;
            perr = pe_q;
            st_d = AT_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AT_IDLE;
      tk_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      pe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tk_q  <= tk_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      pe_q  <= pe_d;
    end
  end
endmodule

// File: rtl/sio_sync_xfer.sv
module sio_sync_xfer
  import sio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  master,
  input  logic  tick,
  input  logic  sck_s,
  input  logic  rdy_s,
  input  logic  rxd,
  input  logic  q_empty,
  input  char_t q_head,
  output logic  q_pop,
  output logic  sck_o,
  output logic  txd_o,
  output logic  done,
  output char_t rdata
);
  logic       act_q, act_d;
  logic       sck_q, sck_d;
  logic       prev_q;
  logic [2:0] cnt_q, cnt_d;
  char_t      tsh_q, tsh_d, rsh_q, rsh_d;
  logic       fall, rise;

  assign fall  = prev_q & ~sck_s;
  assign rise  = ~prev_q & sck_s;
  assign sck_o = sck_q;
  assign txd_o = act_q ? tsh_q[0] : 1'b1;
  assign rdata = rsh_d;

  always_comb begin
    act_d = act_q;
    sck_d = sck_q;
    cnt_d = cnt_q;
    tsh_d = tsh_q;
    rsh_d = rsh_q;
    q_pop = 1'b0;
    done  = 1'b0;
    if (master) begin
      if (!act_q) begin
        sck_d = 1'b1;
        if (en && tick && !rdy_s && !q_empty) begin
          q_pop = 1'b1;
          tsh_d = q_head;
          act_d = 1'b1;
          sck_d = 1'b0;
          cnt_d = '0;
        end
      end else if (tick) begin
        if (!sck_q) begin
          sck_d = 1'b1;
          rsh_d = {rxd, rsh_q[7:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == 3'd7) begin
            act_d = 1'b0;
            done  = 1'b1;
          end
        end else begin
          sck_d = 1'b0;
          tsh_d = tsh_q >> 1;
        end
      end
    end else begin
      sck_d = 1'b1;
      if (en && fall) begin
        if (!act_q) begin
          act_d = 1'b1;
          cnt_d = '0;
          q_pop = ~q_empty;
          tsh_d = q_empty ? char_t'(8'hFF) : q_head;
        end else begin
          tsh_d = tsh_q >> 1;
        end
      end
      if (en && rise && act_q) begin
        rsh_d = {rxd, rsh_q[7:1]};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 3'd7) begin
          act_d = 1'b0;
          done  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b1;
      prev_q <= 1'b1;
      cnt_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      prev_q <= sck_s;
      cnt_q  <= cnt_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
    end
  end

  // R11: a master that sees ready high does not begin a byte
  a_r11_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && !act_q && rdy_s) |=> !act_q);
  // R10: an idle master keeps its clock high
  a_r10_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !act_q && !act_d) |=> sck_q);
endmodule

// File: rtl/sio_channel.sv
module sio_channel
  import sio_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int RX_DEPTH    = 4,
  parameter int TX_DEPTH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sync,
  input  logic       sync_master,
  input  logic       char7,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       err_clr,
  output logic       tx_empty,
  output logic       rx_avail,
  output logic       rx_err,
  output logic       txd,
  input  logic       rxd,
  output logic       sck_n_o,
  output logic       sck_n_oe,
  input  logic       sck_n_i,
  output logic       rdy_n_o,
  output logic       rdy_n_oe,
  input  logic       rdy_n_i
);
  localparam int NSYNC = 3;

  // input synchronizers: bit 0 rxd, bit 1 serial clock, bit 2 ready
  logic [NSYNC-1:0] stg_q [SYNC_STAGES];
  logic [NSYNC-1:0] sync_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= {rdy_n_i, sck_n_i, rxd};
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end
  assign sync_w = stg_q[SYNC_STAGES-1];

  // transmit queue
  char_t tx_head;
  logic  tx_q_empty, tx_q_full, tx_pop;
  logic  at_pop, sy_pop;

  sio_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CHAR_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data), .pop(tx_pop),
    .head(tx_head), .empty(tx_q_empty), .full(tx_q_full)
  );
  assign tx_pop   = mode_sync ? sy_pop : at_pop;
  assign tx_empty = tx_q_empty;

  // asynchronous path
  logic  at_txd, ar_done, ar_ferr, ar_perr;
  char_t ar_data;

  sio_async_tx #(.OVERSAMPLE(OVERSAMPLE)) u_atx (
    .clk(clk), .rst_n(rst_n), .en(~mode_sync), .tick(baud_tick), .char7(char7),
    .par_en(par_en), .par_odd(par_odd), .q_empty(tx_q_empty), .q_head(tx_head),
    .q_pop(at_pop), .txd_o(at_txd)
  );

  sio_async_rx #(.OVERSAMPLE(OVERSAMPLE)) u_arx (
    .clk(clk), .rst_n(rst_n), .en(~mode_sync), .tick(baud_tick), .char7(char7),
    .par_en(par_en), .par_odd(par_odd), .rxd_s(sync_w[0]), .done(ar_done),
    .data(ar_data), .ferr(ar_ferr), .perr(ar_perr)
  );

  // synchronous path
  logic  sy_sck, sy_txd, sy_done;
  char_t sy_data;

  sio_sync_xfer u_sync (
    .clk(clk), .rst_n(rst_n), .en(mode_sync), .master(sync_master), .tick(baud_tick),
    .sck_s(sync_w[1]), .rdy_s(sync_w[2]), .rxd(rxd), .q_empty(tx_q_empty),
    .q_head(tx_head), .q_pop(sy_pop), .sck_o(sy_sck), .txd_o(sy_txd),
    .done(sy_done), .rdata(sy_data)
  );

  // receive queue
  logic  rx_push, rx_q_empty, rx_q_full, rx_overrun;
  char_t rx_in;

  assign rx_push    = mode_sync ? sy_done : ar_done;
  assign rx_in      = mode_sync ? sy_data : ar_data;
  assign rx_overrun = rx_push & rx_q_full;

  sio_fifo #(.DEPTH(RX_DEPTH), .WIDTH(CHAR_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_in), .pop(rd_en),
    .head(rd_data), .empty(rx_q_empty), .full(rx_q_full)
  );
  assign rx_avail = ~rx_q_empty;

  // sticky error flag
  logic err_q, err_d, err_set;
  assign err_set = rx_overrun | (~mode_sync & ar_done & (ar_ferr | ar_perr));

  always_comb begin
    err_d = err_q;
    if (err_clr) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign rx_err = err_q;

  // line outputs
  assign txd      = mode_sync ? sy_txd : at_txd;
  assign sck_n_o  = sy_sck;
  assign sck_n_oe = mode_sync & sync_master;
  assign rdy_n_o  = rx_q_full;
  assign rdy_n_oe = mode_sync & ~sync_master;

  // R9: the error flag holds until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !err_clr) |=> rx_err);
  // R6: a character landing on a full receive queue raises the flag
  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_q_full) |=> rx_err);
  // R4: the transmit queue never drains while no transmitter pops it
  a_r4_hold_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q_full && !tx_pop) |=> !tx_q_empty);
endmodule

// File: tb/sio_channel_tb.sv
module sio_channel_tb_top;
  localparam int BIT_CYC = 32;

  logic       clk, rst_n;
  logic       mode_sync, sync_master, char7, par_en, par_odd, baud_tick;
  logic       wr_en, rd_en, err_clr;
  logic [7:0] wr_data, rd_data;
  logic       tx_empty, rx_avail, rx_err, txd, rxd;
  logic       sck_n_o, sck_n_oe, sck_n_i, rdy_n_o, rdy_n_oe, rdy_n_i;
  logic       loop_en, bench_rxd;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  assign rxd = loop_en ? txd : bench_rxd;

  sio_channel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .sync_master(sync_master),
    .char7(char7), .par_en(par_en), .par_odd(par_odd), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .err_clr(err_clr), .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_err(rx_err),
    .txd(txd), .rxd(rxd), .sck_n_o(sck_n_o), .sck_n_oe(sck_n_oe), .sck_n_i(sck_n_i),
    .rdy_n_o(rdy_n_o), .rdy_n_oe(rdy_n_oe), .rdy_n_i(rdy_n_i)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    baud_tick = 1'b0;
    forever @(posedge clk) baud_tick <= ~baud_tick;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic c7, input logic odd);
    return (^(d & (c7 ? 8'h7F : 8'hFF))) ^ odd;
  endfunction

  task automatic host_write(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    @(negedge clk); b = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_avail(input int maxc);
    int n = 0;
    while (!rx_avail && n < maxc) begin @(negedge clk); n++; end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic c7, input logic pen,
                            input logic podd, input logic bad_par, input logic bad_stop);
    bench_rxd = 1'b0; repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < (c7 ? 7 : 8); i++) begin
      bench_rxd = d[i]; repeat (BIT_CYC) @(negedge clk);
    end
    if (pen) begin
      bench_rxd = par_of(d, c7, podd) ^ bad_par; repeat (BIT_CYC) @(negedge clk);
    end
    if (bad_stop) begin
      bench_rxd = 1'b0; repeat (BIT_CYC / 2 + 4) @(negedge clk);
    end
    bench_rxd = 1'b1; repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic capture_tx(input int nbits, output logic [11:0] bits);
    int n = 0;
    bits = '0;
    while (txd !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    repeat (BIT_CYC / 2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bits[i] = txd; repeat (BIT_CYC) @(negedge clk);
    end
  endtask

  task automatic slave_xfer(input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 0; i < 8; i++) begin
      bench_rxd = mosi[i]; sck_n_i = 1'b0;
      repeat (8) @(negedge clk);
      miso[i] = txd; sck_n_i = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  b, got, exp_b;
    logic [11:0] bits;
    void'($urandom(32'd4711));
    rst_n = 1'b0; mode_sync = 1'b0; sync_master = 1'b0; char7 = 1'b0;
    par_en = 1'b0; par_odd = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    err_clr = 1'b0; sck_n_i = 1'b1; rdy_n_i = 1'b1; loop_en = 1'b0; bench_rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_avail", rx_avail, 0);
    check("R1 rx_err", rx_err, 0);
    check("R1 txd", txd, 1);
    check("R1 clk/oe", {sck_n_o, sck_n_oe, rdy_n_oe}, 3'b100);

    // R2 frame layout: 8 bits, odd parity
    par_en = 1'b1; par_odd = 1'b1;
    host_write(8'h5C);
    capture_tx(11, bits);
    check("R2 start", bits[0], 0);
    check("R2 data8", bits[8:1], 8'h5C);
    check("R2 parity", bits[9], par_of(8'h5C, 1'b0, 1'b1));
    check("R2 stop", bits[10], 1);
    // R2 frame layout: 7 bits, no parity
    par_en = 1'b0; char7 = 1'b1;
    host_write(8'hB3);
    capture_tx(9, bits);
    check("R2 data7", bits[7:1], 7'h33);
    check("R2 stop7", bits[8], 1);
    repeat (BIT_CYC) @(negedge clk);

    // R3 looped-back asynchronous traffic, random formats
    loop_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      b = 8'($urandom); char7 = 1'($urandom); par_en = 1'($urandom); par_odd = 1'($urandom);
      host_write(b);
      wait_avail(800);
      host_read(got);
      exp_b = char7 ? (b & 8'h7F) : b;
      check("R3 loopback", got, exp_b);
      repeat (BIT_CYC) @(negedge clk);
    end
    check("R3 no error", rx_err, 0);

    // R4 transmit queue depth
    char7 = 1'b0; par_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      wr_en = 1'b1; wr_data = 8'hA0 + 8'(k); @(negedge clk);
    end
    wr_en = 1'b0;
    check("R4 tx_empty after writes", tx_empty, 0);
    for (int k = 0; k < 3; k++) begin
      wait_avail(800);
      host_read(got);
      check("R4 order", got, 8'hA0 + 8'(k));
    end
    repeat (800) @(negedge clk);
    check("R4 fourth dropped", rx_avail, 0);
    check("R4 drained", tx_empty, 1);

    // R5 read on empty, head visibility
    loop_en = 1'b0;
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R5 empty read", rx_avail, 0);
    send_frame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 avail", rx_avail, 1);
    check("R5 head", rd_data, 8'h6E);
    host_read(got);
    check("R5 emptied", rx_avail, 0);

    // R6 overrun
    for (int k = 1; k <= 4; k++) send_frame(8'(k * 17), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 no error at four", rx_err, 0);
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 overrun flag", rx_err, 1);
    for (int k = 1; k <= 4; k++) begin
      host_read(got);
      check("R6 kept bytes", got, 8'(k * 17));
    end
    check("R6 fifth dropped", rx_avail, 0);

    // R9 sticky until cleared
    repeat (50) @(negedge clk);
    check("R9 still set", rx_err, 1);
    clear_err();
    check("R9 cleared", rx_err, 0);

    // R7 framing error
    send_frame(8'h9A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 framing flag", rx_err, 1);
    host_read(got);
    check("R7 byte kept", got, 8'h9A);
    repeat (BIT_CYC) @(negedge clk);
    check("R7 no false start", rx_avail, 0);
    clear_err();

    // R8 parity
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h3B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 good parity", rx_err, 0);
    host_read(got);
    send_frame(8'h3B, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R8 bad parity", rx_err, 1);
    host_read(got);
    clear_err();
    par_en = 1'b0;

    // R10 synchronous master
    mode_sync = 1'b1; sync_master = 1'b1; rdy_n_i = 1'b0; bench_rxd = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 oe", {sck_n_oe, rdy_n_oe}, 2'b10);
    bench_rxd = 1'b0;
    host_write(8'hC6);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_n_o);
      got[i] = txd;
      bench_rxd = 8'h5A >> (i + 1);
    end
    check("R10 bits out", got, 8'hC6);
    repeat (4) @(negedge clk);
    host_read(got);
    check("R10 bits in", got, 8'h5A);
    loop_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      host_write(b);
      wait_avail(300);
      host_read(got);
      check("R10 loopback", got, b);
    end

    // R11 ready gating
    rdy_n_i = 1'b1;
    repeat (6) @(negedge clk);
    host_write(8'h42);
    repeat (100) @(negedge clk);
    check("R11 held queued", tx_empty, 0);
    check("R11 clock idle", sck_n_o, 1);
    rdy_n_i = 1'b0;
    wait_avail(300);
    host_read(got);
    check("R11 released", got, 8'h42);

    // R12 synchronous slave
    loop_en = 1'b0; sync_master = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 oe", {sck_n_oe, rdy_n_oe, rdy_n_o}, 3'b010);
    host_write(8'hA5);
    slave_xfer(8'h3C, got);
    check("R12 sent head", got, 8'hA5);
    host_read(b);
    check("R12 received", b, 8'h3C);
    slave_xfer(8'h81, got);
    check("R12 empty fill", got, 8'hFF);
    host_read(b);
    check("R12 received2", b, 8'h81);
    for (int k = 0; k < 4; k++) begin
      slave_xfer(8'h10 + 8'(k), got);
      if (k == 2) check("R12 room left", rdy_n_o, 0);
    end
    check("R12 not ready when full", rdy_n_o, 1);
    for (int k = 0; k < 4; k++) begin
      host_read(b);
      check("R12 queued order", b, 8'h10 + 8'(k));
    end
    check("R12 ready again", rdy_n_o, 0);

    finish_run();
  end
endmodule